// File: doc/BRIEF.md
# Converter Clock Divider and Power-Up Sequencer

This block produces the sampling-clock enable for a successive-approximation converter and decides when that converter may start converting. A seven-bit counter runs on the system clock only while the block is enabled. A three-bit divide code picks one of its taps, which gives a one-cycle enable pulse at the system rate divided by 2 up to 128. The counter is cleared on every cycle in which the enable is low. The divide code is captured only while the block is disabled, so a code written during operation cannot stretch or shorten a power-up that is already running.

Once enabled, a small state machine steps through the power-up. It first waits for the supply to report that it is stable. It then counts a programmable start-up interval. In differential mode it adds a short settling interval after that. Both intervals are counted in pulses of the divided clock. When the last interval ends, the ready flag rises. Dropping the enable at any point returns everything to idle at the next clock edge.

Top module: `convclk_startup`

## Requirements
- R1: The counter counts enabled cycles from 0. In enabled cycle j, `cclk_en_o` is high for exactly that one cycle when (j+1) mod D = 0. D = 2^max(code,1), so codes 0 and 1 both divide by 2, code 2 by 4, and so on up to code 7, which divides by 128.
- R2: While `en_i` is low, `cclk_en_o` stays low and the counter is cleared. Each new enable therefore restarts the pulse pattern at j = 0.
- R3: The divide code is captured on every clock edge at which `en_i` is low. Changes on `div_sel_i` while `en_i` is high have no effect on the pulse spacing.
- R4: `phase_o` encodes the phases as 0 idle, 1 waiting for supply, 2 start-up, 3 settling, 4 ready. The first enabled cycle moves idle to 1. Phase 1 holds until `supply_ok_i` is high.
- R5: On leaving phase 1, `su_len_i`, `diff_mode_i` and `settle_i` are captured. Start-up then lasts `su_len_i`+1 divided-clock pulses.
- R6: If the captured differential flag is set, a settling phase of 1, 2, 4 or 8 divided-clock pulses follows (for settle codes 0 to 3). Otherwise start-up goes straight to ready.
- R7: `ready_o` is high exactly while `phase_o` is 4. It rises only on the edge that ends the last required phase.
- R8: A low `en_i` at a clock edge puts the phase at idle and clears `ready_o` after that edge, from any phase.
- R9: Synchronous active-high `rst` clears the counter, the captured code and the phase. After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Block enable; low holds counter and sequencer in reset |
| div_sel_i | input | 3 | Divide code, captured while disabled |
| su_len_i | input | 6 | Start-up length minus one, in divided-clock pulses |
| settle_i | input | 2 | Settling length code (1, 2, 4, 8 pulses) |
| diff_mode_i | input | 1 | Differential mode; adds the settling phase |
| supply_ok_i | input | 1 | Supply-stable indication |
| cclk_en_o | output | 1 | One-cycle divided converter clock enable |
| ready_o | output | 1 | Power-up finished; conversions allowed |
| phase_o | output | 3 | Active power-up phase |

## Verification
The bench measures the exact number of cycles from enable to ready for every settle code and for single-ended mode. An off-by-one in either interval counter, or a settling phase entered without differential mode, shifts those counts by whole divided periods. It rewrites the divide code right after enabling and times the first pulses. A design that failed to freeze the code would pulse after 1 cycle instead of 127. It also drops the enable in the middle of start-up and re-enables it. A counter that is not cleared would place the next pulse off the expected grid, and a sequencer that does not reset would keep a stale phase or ready.

// File: rtl/convclk_pkg.sv
package convclk_pkg;

    localparam int PRE_W_DEF = 7;
    localparam int SEL_W_DEF = 3;
    localparam int SU_W_DEF  = 6;
    localparam int SET_W_DEF = 2;
    localparam int PH_W      = 3;

    typedef enum logic [PH_W-1:0] {
        PH_IDLE    = 3'd0,
        PH_SUPPLY  = 3'd1,
        PH_STARTUP = 3'd2,
        PH_SETTLE  = 3'd3,
        PH_READY   = 3'd4
    } phase_e;

endpackage

// File: rtl/convclk_prescaler.sv
module convclk_prescaler #(
    parameter int PRE_W = 7,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [SEL_W-1:0] div_sel_i,
    output logic             tick_o,
    output logic [SEL_W-1:0] sel_q_o
);
    localparam int TAPS = 1 << SEL_W;

    logic [PRE_W-1:0] cnt_q;
    logic [SEL_W-1:0] sel_q;
    logic [TAPS-1:0]  tap_hit;
    logic [SEL_W-1:0] tap_idx;

    // Counter runs only while enabled; code is captured only while disabled
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sel_q <= '0;
        end else if (!en_i) begin
            cnt_q <= '0;
            sel_q <= div_sel_i;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Tap i fires when the low i+1 counter bits are all ones (divide by 2^(i+1))
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        if (i < PRE_W) begin : g_live
            assign tap_hit[i] = &cnt_q[i:0];
        end else begin : g_top
            assign tap_hit[i] = &cnt_q;
        end
    end

    // Codes 0 and 1 both use the divide-by-two tap
    always_comb begin
        tap_idx = (sel_q == '0) ? '0 : sel_q - 1'b1;
    end

    assign tick_o  = en_i & tap_hit[tap_idx];
    assign sel_q_o = sel_q;

endmodule

// File: rtl/convclk_seq_fsm.sv
module convclk_seq_fsm
    import convclk_pkg::*;
#(
    parameter int SU_W  = 6,
    parameter int SET_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             supply_ok_i,
    input  logic [SU_W-1:0]  su_len_i,
    input  logic [SET_W-1:0] settle_i,
    input  logic             diff_i,
    output phase_e           phase_o,
    output logic             ready_o
);
    localparam int ST_CW = (1 << SET_W) - 1;

    typedef struct packed {
        logic [SU_W-1:0]  su_cnt;
        logic [ST_CW-1:0] st_cnt;
        logic             diff;
    } seq_cfg_t;

    phase_e   state_q, state_d;
    seq_cfg_t cfg_q;
    logic     su_done, st_done, capture;

    assign su_done = tick_i && (cfg_q.su_cnt == '0);
    assign st_done = tick_i && (cfg_q.st_cnt == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:    state_d = PH_SUPPLY;
            PH_SUPPLY:  if (supply_ok_i) state_d = PH_STARTUP;
            PH_STARTUP: if (su_done) state_d = cfg_q.diff ? PH_SETTLE : PH_READY;
            PH_SETTLE:  if (st_done) state_d = PH_READY;
            PH_READY:   state_d = PH_READY;
            default:    state_d = PH_IDLE;
        endcase
        if (!en_i) state_d = PH_IDLE;
    end

    assign capture = en_i && (state_q == PH_SUPPLY) && supply_ok_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            if (capture) begin
                cfg_q.su_cnt <= su_len_i;
                cfg_q.st_cnt <= ST_CW'((1 << settle_i) - 1);
                cfg_q.diff   <= diff_i;
            end else if (en_i && state_q == PH_STARTUP && tick_i && !su_done) begin
                cfg_q.su_cnt <= cfg_q.su_cnt - 1'b1;
            end else if (en_i && state_q == PH_SETTLE && tick_i && !st_done) begin
                cfg_q.st_cnt <= cfg_q.st_cnt - 1'b1;
            end
        end
    end

    assign phase_o = state_q;
    assign ready_o = (state_q == PH_READY);

endmodule

// File: rtl/convclk_startup.sv
module convclk_startup
    import convclk_pkg::*;
#(
    parameter int PRE_W = PRE_W_DEF,
    parameter int SEL_W = SEL_W_DEF,
    parameter int SU_W  = SU_W_DEF,
    parameter int SET_W = SET_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [SEL_W-1:0] div_sel_i,
    input  logic [SU_W-1:0]  su_len_i,
    input  logic [SET_W-1:0] settle_i,
    input  logic             diff_mode_i,
    input  logic             supply_ok_i,
    output logic             cclk_en_o,
    output logic             ready_o,
    output logic [PH_W-1:0]  phase_o
);
    logic             tick;
    logic [SEL_W-1:0] sel_live;
    phase_e           phase;

    convclk_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en_i),
        .div_sel_i (div_sel_i),
        .tick_o    (tick),
        .sel_q_o   (sel_live)
    );

    convclk_seq_fsm #(.SU_W(SU_W), .SET_W(SET_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .en_i        (en_i),
        .tick_i      (tick),
        .supply_ok_i (supply_ok_i),
        .su_len_i    (su_len_i),
        .settle_i    (settle_i),
        .diff_i      (diff_mode_i),
        .phase_o     (phase),
        .ready_o     (ready_o)
    );

    assign cclk_en_o = tick;
    assign phase_o   = phase;

endmodule

// File: rtl/convclk_startup_chk.sv
module convclk_startup_chk
    import convclk_pkg::*;
#(
    parameter int SEL_W = SEL_W_DEF
) (
    input logic             clk,
    input logic             rst,
    input logic             en_i,
    input logic             supply_ok_i,
    input logic             cclk_en_o,
    input logic             ready_o,
    input logic [PH_W-1:0]  phase_o,
    input logic [SEL_W-1:0] sel_q
);
    // R1: the enable pulse is never wider than one cycle
    a_r1_pulse_single: assert property (@(posedge clk) disable iff (rst)
        cclk_en_o |=> !cclk_en_o);

    // R3: the captured code does not move while the block stays enabled
    a_r3_sel_frozen: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && en_i && $past(en_i)) |-> $stable(sel_q));

    // R4: idle leaves for the supply wait on an enabled cycle
    a_r4_idle_exit: assert property (@(posedge clk) disable iff (rst)
        (en_i && phase_o == PH_IDLE) |=> (phase_o == PH_SUPPLY));

    // R4: the supply wait holds until the supply is reported stable
    a_r4_supply_hold: assert property (@(posedge clk) disable iff (rst)
        (en_i && phase_o == PH_SUPPLY && !supply_ok_i) |=> (phase_o == PH_SUPPLY));

    // R7: ready only rises on a divided pulse that ends start-up or settling
    a_r7_ready_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> ($past(cclk_en_o) &&
            ($past(phase_o) == PH_STARTUP || $past(phase_o) == PH_SETTLE)));

    // R8: disable returns to idle and drops ready at the next edge
    a_r8_off_idle: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (phase_o == PH_IDLE && !ready_o));

endmodule

bind convclk_startup convclk_startup_chk #(.SEL_W(SEL_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .en_i        (en_i),
    .supply_ok_i (supply_ok_i),
    .cclk_en_o   (cclk_en_o),
    .ready_o     (ready_o),
    .phase_o     (phase_o),
    .sel_q       (sel_live)
);

// File: tb/convclk_startup_bench.sv
module convclk_startup_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       sup = 1'b0;
    logic       diff = 1'b0;
    logic [2:0] sel = '0;
    logic [5:0] su = '0;
    logic [1:0] st = '0;
    logic       cen, rdy;
    logic [2:0] ph;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;

    // reference model state
    int m_j = 0, m_sel = 0, m_state = 0, m_cnt = 0, m_set = 0;
    bit m_diff = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    convclk_startup u_convclk_startup (
        .clk(clk), .rst(rst), .en_i(en), .div_sel_i(sel), .su_len_i(su),
        .settle_i(st), .diff_mode_i(diff), .supply_ok_i(sup),
        .cclk_en_o(cen), .ready_o(rdy), .phase_o(ph)
    );

    function automatic int div_of(int s);
        return 1 << ((s == 0) ? 1 : s);
    endfunction

    function automatic bit exp_tick(int j, int s, bit e);
        return e && (((j + 1) % div_of(s)) == 0);
    endfunction

    always @(posedge clk) begin : ref_model
        bit t;
        t = exp_tick(m_j, m_sel, en);
        if (rst) begin
            m_j = 0; m_sel = 0; m_state = 0; m_cnt = 0;
        end else if (!en) begin
            m_j = 0; m_sel = int'(sel); m_state = 0;
        end else begin
            m_j = (m_j + 1) % 128;
            case (m_state)
                0: m_state = 1;
                1: if (sup) begin
                       m_state = 2; m_cnt = int'(su); m_diff = diff; m_set = int'(st);
                   end
                2: if (t) begin
                       if (m_cnt == 0) begin
                           if (m_diff) begin m_state = 3; m_cnt = (1 << m_set) - 1; end
                           else m_state = 4;
                       end else m_cnt = m_cnt - 1;
                   end
                3: if (t) begin
                       if (m_cnt == 0) m_state = 4; else m_cnt = m_cnt - 1;
                   end
                default: ;
            endcase
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one cycle, compared against the model at the falling edge
    task automatic step();
        @(negedge clk);
        check(cen == exp_tick(m_j, m_sel, en), "R1", "cclk_en", int'(cen), int'(exp_tick(m_j, m_sel, en)));
        check(int'(ph) == m_state, "R4", "phase", int'(ph), m_state);
        check(rdy == (m_state == 4), "R7", "ready", int'(rdy), int'(m_state == 4));
    endtask

    task automatic count_to_ready(output int n);
        n = 0;
        do begin step(); n++; end while (!rdy && n < 5000);
    endtask

    task automatic count_to_tick(output int n);
        n = 0;
        do begin step(); n++; end while (!cen && n < 5000);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        int n;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();
        // R9: reset state
        check(ph == 3'd0 && !rdy && !cen, "R9", "reset outputs", int'({ph, rdy, cen}), 0);

        // R6: divide by 4, start-up 4 pulses, differential, settle 4 pulses -> ready at j=32
        sel = 3'd2; su = 6'd3; diff = 1'b1; st = 2'd2; sup = 1'b1;
        step();
        en = 1'b1;
        count_to_ready(n);
        check(n == 32, "R6", "cycles to ready diff /4", n, 32);
        en = 1'b0;
        step();
        check(ph == 3'd0 && !rdy, "R8", "disable from ready", int'({ph, rdy}), 0);

        // R5: divide by 2 via code 0, single pulse start-up, single-ended -> ready at j=4
        sel = 3'd0; su = 6'd0; diff = 1'b0; st = 2'd3;
        step();
        en = 1'b1;
        count_to_ready(n);
        check(n == 4, "R5", "cycles to ready single-ended", n, 4);

        // R6: each settle code, divide by 2 via code 1
        for (int c = 0; c < 4; c++) begin
            en = 1'b0; sel = 3'd1; su = 6'd0; diff = 1'b1; st = 2'(c);
            step();
            en = 1'b1;
            count_to_ready(n);
            check(n == 4 + 2 * (1 << c), "R6", "settle code timing", n, 4 + 2 * (1 << c));
        end

        // R3: code 7 captured, then rewritten to 1 while enabled
        en = 1'b0; sel = 3'd7;
        step();
        en = 1'b1; sel = 3'd1;
        count_to_tick(n);
        check(n == 127, "R3", "first pulse with frozen code", n, 127);
        count_to_tick(n);
        check(n == 128, "R1", "pulse spacing /128", n, 128);

        // R4: supply wait holds
        en = 1'b0; sup = 1'b0; sel = 3'd3; su = 6'd63;
        step();
        en = 1'b1;
        repeat (20) step();
        check(ph == 3'd1, "R4", "supply wait held", int'(ph), 1);
        sup = 1'b1;
        repeat (100) step();
        check(ph == 3'd2, "R5", "in start-up", int'(ph), 2);

        // R8/R2: drop enable mid start-up, then restart pattern
        en = 1'b0; sel = 3'd0;
        step();
        check(ph == 3'd0 && !cen, "R8", "disable mid start-up", int'({ph, cen}), 0);
        check(!cen, "R2", "no pulse while disabled", int'(cen), 0);
        en = 1'b1;
        count_to_tick(n);
        check(n == 1, "R2", "pattern restarts after re-enable", n, 1);

        // random episodes
        for (int e = 0; e < 40; e++) begin
            en = 1'b0;
            sel = 3'($urandom_range(0, 7)); su = 6'($urandom_range(0, 63));
            st = 2'($urandom_range(0, 3)); diff = 1'($urandom_range(0, 1));
            sup = 1'($urandom_range(0, 1));
            repeat ($urandom_range(1, 3)) step();
            en = 1'b1;
            for (int i = 0; i < int'($urandom_range(20, 1500)); i++) begin
                if ($urandom_range(0, 7) == 0) sel = 3'($urandom_range(0, 7));
                if ($urandom_range(0, 15) == 0) su = 6'($urandom_range(0, 63));
                if ($urandom_range(0, 15) == 0) diff = 1'($urandom_range(0, 1));
                if ($urandom_range(0, 15) == 0) st = 2'($urandom_range(0, 3));
                if (!sup && $urandom_range(0, 19) == 0) sup = 1'b1;
                step();
            end
        end
        en = 1'b0;
        step();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule